// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave (8K x 8)

This block is the device end of a two-wire serial byte memory. The master's clock and data lines come in as plain inputs. The block pulls the data line low through a single open-drain enable output. A fast system clock oversamples both lines. Bus start and stop conditions and clock edges are recovered from that sampled view, and a byte-level state machine walks through the transaction. The storage is an array of 2^ADDR_W bytes built from registers inside the block. With the default ADDR_W of 13 the array holds 8192 bytes.

A transaction opens with a device byte. The block then takes two pointer bytes and after that any number of data bytes, or it streams data bytes back to the master. One pointer register serves both directions. It advances after every byte moved, so a read with no pointer bytes continues from where the last access stopped. A write cycle finishes at once: there is no busy time after a stop, and the master may begin the next transaction immediately.

Top module: `twi_mem_slave`

## Requirements
- R1: The first byte after a start is a device byte. Bits 7..4 must equal 1010 and bits 3..1 must equal `dev_sel`. When both match, the block pulls SDA low during the 9th clock. Bit 0 picks the direction: 0 writes and 1 reads.
- R2: When the device byte does not match, the block acknowledges nothing and writes nothing until the next start condition.
- R3: In a write, the block acknowledges the high pointer byte, the low pointer byte and every data byte. Data byte k is stored at pointer+k.
- R4: Only the low ADDR_W-8 bits of the high pointer byte are used. With the default, bits 7..5 are ignored.
- R5: A write that carries only the two pointer bytes and then a stop loads the pointer and leaves memory unchanged.
- R6: A read without pointer bytes starts at the pointer value. That value is one past the last byte written or read.
- R7: After each read byte, a master acknowledge (SDA low in the 9th clock) makes the block shift out the byte at the next address.
- R8: The pointer wraps from 2^ADDR_W-1 (1FFFh by default) to 0 in both reads and writes.
- R9: A selective read is a write device byte, then the two pointer bytes, then a repeated start and a read device byte. It returns data starting at the loaded address.
- R10: A read ends cleanly in any of four ways: a master no-acknowledge followed by a stop, a no-acknowledge followed by a start, a stop in the 9th clock, or a start in the 9th clock. After any of them the block releases SDA and drives no more data. A stop returns the block to idle with SDA released.
- R11: SDA is sampled on rising SCL. The block changes its SDA drive only while SCL is low.
- R12: A start condition seen in any state, including in the middle of a byte, clears the bit count and makes the next 8 bits a device byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | 3 | Static device select, compared with device byte bits 3..1 |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | When 1, the block pulls SDA low |

## Verification
An SCL edge at the pins is seen by the state machine two to three system cycles later, after two synchronizer flops and one register. An acknowledge or data bit therefore appears on `sda_oe` about three cycles after SCL falls, and a write lands in memory one cycle after the 8th rising edge is detected. The bench holds each SCL phase for 10 system cycles. It changes SDA 5 cycles into the low phase and reads the bus 5 cycles into the high phase. Every acknowledge, read bit and released-bus check is therefore taken long after the block's response has settled and well before the next edge. Memory and pointer effects that cannot be seen on the pins are checked by reading them back through a later bus transaction.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_PHI,
        ST_PLO,
        ST_WDAT,
        ST_RDAT,
        ST_SKIP
    } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES:0] scl_pipe_q, sda_pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-1:0], scl_in};
            sda_pipe_q <= {sda_pipe_q[STAGES-1:0], sda_in};
        end
    end

    logic scl_prev, sda_prev;
    assign scl_lvl   = scl_pipe_q[STAGES-1];
    assign sda_lvl   = sda_pipe_q[STAGES-1];
    assign scl_prev  = scl_pipe_q[STAGES];
    assign sda_prev  = sda_pipe_q[STAGES];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] dev_sel,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe
);
    localparam int HI_W = ADDR_W - 8;

    typedef struct packed {
        twi_state_e        st;
        logic [3:0]        bits;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] ptr;
        logic              ack;
        logic              oe;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic we;
    logic [7:0] rd_data, in_byte;

    twi_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_i),
        .sda_in    (sda_i),
        .scl_lvl   (scl_s),
        .sda_lvl   (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    twi_mem_array #(.AW(ADDR_W), .DW(8)) i_mem (
        .clk   (clk),
        .we    (we),
        .waddr (ctl_q.ptr),
        .wdata (in_byte),
        .raddr (ctl_q.ptr),
        .rdata (rd_data)
    );

    assign in_byte = {ctl_q.sh[6:0], sda_s};

    always_comb begin
        ctl_d = ctl_q;
        we    = 1'b0;
        if (stop_evt) begin
            ctl_d.st   = ST_IDLE;
            ctl_d.bits = '0;
            ctl_d.oe   = 1'b0;
        end else if (start_evt) begin
            ctl_d.st   = ST_DEV;
            ctl_d.bits = '0;
            ctl_d.oe   = 1'b0;
        end else if (ctl_q.st == ST_RDAT) begin
            // transmit: bit k driven after the fall that precedes its rise
            if (scl_rise) begin
                if (ctl_q.bits == 4'd8) begin
                    if (sda_s) ctl_d.st = ST_SKIP;   // master declined more data
                    else       ctl_d.bits = 4'd9;
                end else begin
                    ctl_d.bits = ctl_q.bits + 4'd1;
                end
            end else if (scl_fall) begin
                if (ctl_q.bits == 4'd8) begin
                    ctl_d.oe  = 1'b0;
                    ctl_d.ptr = ctl_q.ptr + 1'b1;
                end else if (ctl_q.bits == 4'd9) begin
                    ctl_d.sh   = rd_data;
                    ctl_d.oe   = ~rd_data[7];
                    ctl_d.bits = '0;
                end else if (ctl_q.bits != 4'd0) begin
                    ctl_d.sh = {ctl_q.sh[6:0], 1'b0};
                    ctl_d.oe = ~ctl_q.sh[6];
                end
            end
        end else if (ctl_q.st != ST_IDLE && ctl_q.st != ST_SKIP) begin
            // receive states
            if (scl_rise) begin
                if (ctl_q.bits < 4'd8) begin
                    ctl_d.sh   = in_byte;
                    ctl_d.bits = ctl_q.bits + 4'd1;
                    if (ctl_q.bits == 4'd7) begin
                        ctl_d.ack = 1'b1;
                        case (ctl_q.st)
                            ST_DEV:  ctl_d.ack = (in_byte[7:1] == {DEV_TYPE, dev_sel});
                            ST_PHI:  ctl_d.ptr[ADDR_W-1:8] = in_byte[HI_W-1:0];
                            ST_PLO:  ctl_d.ptr[7:0] = in_byte;
                            default: begin
                                we        = 1'b1;
                                ctl_d.ptr = ctl_q.ptr + 1'b1;
                            end
                        endcase
                    end
                end else begin
                    ctl_d.bits = 4'd9;
                end
            end else if (scl_fall) begin
                if (ctl_q.bits == 4'd8) begin
                    ctl_d.oe = ctl_q.ack;
                    if (!ctl_q.ack) ctl_d.st = ST_SKIP;
                end else if (ctl_q.bits == 4'd9) begin
                    ctl_d.oe   = 1'b0;
                    ctl_d.bits = '0;
                    case (ctl_q.st)
                        ST_DEV: begin
                            if (ctl_q.sh[0]) begin
                                ctl_d.st = ST_RDAT;
                                ctl_d.sh = rd_data;
                                ctl_d.oe = ~rd_data[7];
                            end else begin
                                ctl_d.st = ST_PHI;
                            end
                        end
                        ST_PHI:  ctl_d.st = ST_PLO;
                        default: ctl_d.st = ST_WDAT;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, bits: '0, sh: '0, ptr: '0, ack: 1'b0, oe: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe = ctl_q.oe;

    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.oe != $past(ctl_q.oe)) |-> !scl_s);

    p_bits_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.bits <= 4'd9);

    p_start_rearm_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt && !stop_evt |=> (ctl_q.st == ST_DEV) && (ctl_q.bits == 4'd0));

    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (ctl_q.st == ST_IDLE) && !ctl_q.oe);

    p_skip_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SKIP) |-> !we);

    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ctl_q.ptr == ADDR_W'($past(ctl_q.ptr) + 1'b1));
endmodule

// File: tb/test_twi_mem_slave.sv
module test_twi_mem_slave;
    localparam int MASK = 8191;
    localparam logic [7:0] DEV_W = 8'hAA;   // 1010 101 0
    localparam logic [7:0] DEV_R = 8'hAB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_ln;
    logic [7:0] model [8192];
    int ptr = 0;
    int nvec = 0;
    int nbad = 0;
    int r11_viol = 0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;

    always #4 clk = ~clk;

    assign sda_ln = sda_m & ~sda_oe;

    twi_mem_slave i_twi_mem_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_sel (3'b101),
        .scl_i   (scl_m),
        .sda_i   (sda_ln),
        .sda_oe  (sda_oe)
    );

    // R11 monitor: drive may only change while SCL is low
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe && scl_m) r11_viol++;
        prev_oe <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_clk(input logic b, output logic s);
        sda_m = b; tick(5);
        scl_m = 1'b1; tick(5);
        s = sda_ln; tick(5);
        scl_m = 1'b0; tick(5);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(5);
        scl_m = 1'b1; tick(5);
        sda_m = 1'b0; tick(5);
        scl_m = 1'b0; tick(5);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(5);
        scl_m = 1'b1; tick(5);
        sda_m = 1'b1; tick(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ok);
        logic s;
        for (int i = 7; i >= 0; i--) bit_clk(b[i], s);
        bit_clk(1'b1, s);
        ok = !s;
    endtask

    task automatic recv_bits(output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_clk(1'b1, s);
            b[i] = s;
        end
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        logic s;
        recv_bits(b);
        bit_clk(!mack, s);
    endtask

    task automatic set_ptr(input int a, input string req);
        logic ok;
        int nak = 0;
        send_byte(DEV_W, ok); if (!ok) nak++;
        send_byte(8'((a >> 8) & 255), ok); if (!ok) nak++;
        send_byte(8'(a & 255), ok); if (!ok) nak++;
        check(nak == 0, req, nak, 0);
        ptr = a & MASK;
    endtask

    task automatic mem_write(input int a, input int n, input int seed, input string req);
        logic ok;
        logic [7:0] v;
        int nak = 0;
        bus_start;
        set_ptr(a, req);
        for (int i = 0; i < n; i++) begin
            v = 8'((seed + i * 29) & 255);
            send_byte(v, ok); if (!ok) nak++;
            model[(a + i) & MASK] = v;
        end
        bus_stop;
        ptr = (a + n) & MASK;
        check(nak == 0, req, nak, 0);
    endtask

    task automatic mem_read(input bit sel, input int a, input int n, input string req);
        logic ok;
        logic [7:0] b;
        bus_start;
        if (sel) begin
            set_ptr(a, req);
            bus_start;
        end
        send_byte(DEV_R, ok);
        check(ok, req, ok, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            check(b === model[ptr], req, b, model[ptr]);
            ptr = (ptr + 1) & MASK;
        end
        bus_stop;
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic ok;
        logic s;
        logic [7:0] b;
        int quiet;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check(sda_oe == 1'b0, "R10 reset release", sda_oe, 0);

        // R1 / R2: sweep type nibble and select field
        for (int t = 0; t < 2; t++) begin
            for (int sel = 0; sel < 8; sel++) begin
                bus_start;
                send_byte({(t == 0) ? 4'b1010 : 4'b1011, 3'(sel), 1'b0}, ok);
                bus_stop;
                check(ok == (t == 0 && sel == 5), "R1", ok, (t == 0 && sel == 5));
            end
        end

        // R3 write, R9/R7 selective sequential read
        mem_write(32'h0100, 16, 7, "R3");
        mem_read(1'b1, 32'h0100, 16, "R9/R7");

        // R6 current-address read continues after last access
        mem_write(32'h0300, 4, 100, "R3");
        mem_read(1'b1, 32'h0300, 1, "R9");
        mem_read(1'b0, 0, 2, "R6");
        check(ptr == 32'h0303, "R6 pointer", ptr, 32'h0303);

        // R5 pointer-only write leaves memory alone
        bus_start; set_ptr(32'h0302, "R5"); bus_stop;
        mem_read(1'b0, 0, 1, "R5");

        // R4 upper bits of high pointer byte ignored
        bus_start; set_ptr(32'hE301, "R4"); bus_stop;
        mem_read(1'b0, 0, 1, "R4");
        mem_write(32'hA050, 2, 201, "R4");
        mem_read(1'b1, 32'h0050, 2, "R4");

        // R8 wrap in writes and reads
        mem_write(32'h1FFE, 3, 55, "R8");
        mem_read(1'b1, 32'h1FFE, 3, "R8");
        mem_read(1'b1, 32'h1FFF, 2, "R8");

        // R2 mismatching device: nothing acknowledged or written
        bus_start;
        quiet = 0;
        send_byte(8'hA2, ok); if (ok) quiet++;
        send_byte(8'h03, ok); if (ok) quiet++;
        send_byte(8'h00, ok); if (ok) quiet++;
        send_byte(8'h5A, ok); if (ok) quiet++;
        bus_stop;
        check(quiet == 0, "R2 acks", quiet, 0);
        mem_read(1'b1, 32'h0300, 1, "R2");

        // R10 (a): no-acknowledge then stop; bus stays quiet
        bus_start; set_ptr(32'h0100, "R10"); bus_start;
        send_byte(DEV_R, ok);
        recv_byte(1'b1, b); check(b === model[32'h0100], "R10", b, model[32'h0100]);
        recv_byte(1'b0, b); check(b === model[32'h0101], "R10", b, model[32'h0101]);
        quiet = 0;
        for (int i = 0; i < 9; i++) begin
            bit_clk(1'b1, s);
            if (!s) quiet++;
        end
        check(quiet == 0, "R10 released after nack", quiet, 0);
        bus_stop;
        ptr = 32'h0102;

        // R10 (b): no-acknowledge then repeated start
        bus_start; send_byte(DEV_R, ok);
        recv_byte(1'b0, b); check(b === model[32'h0102], "R10", b, model[32'h0102]);
        ptr = 32'h0103;
        mem_read(1'b0, 0, 1, "R10");

        // R10 (c): stop inside 9th clock
        bus_start; send_byte(DEV_R, ok);
        recv_bits(b); check(b === model[32'h0104], "R10", b, model[32'h0104]);
        sda_m = 1'b0; tick(5); scl_m = 1'b1; tick(5); sda_m = 1'b1; tick(10);
        check(sda_oe == 1'b0, "R10 stop in 9th", sda_oe, 0);
        ptr = 32'h0105;
        mem_read(1'b0, 0, 1, "R10");

        // R10 (d): start inside 9th clock
        bus_start; send_byte(DEV_R, ok);
        recv_bits(b); check(b === model[32'h0106], "R10", b, model[32'h0106]);
        sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(5); sda_m = 1'b0; tick(5); scl_m = 1'b0; tick(5);
        check(sda_oe == 1'b0, "R10 start in 9th", sda_oe, 0);
        send_byte(DEV_R, ok); check(ok, "R10", ok, 1);
        recv_byte(1'b0, b); check(b === model[32'h0107], "R10", b, model[32'h0107]);
        bus_stop;
        ptr = 32'h0108;

        // R12: start in the middle of a byte
        bus_start;
        for (int i = 0; i < 4; i++) bit_clk(i[0] ? 1'b0 : 1'b1, s);
        mem_read(1'b1, 32'h0108, 2, "R12");
        bus_start;
        for (int i = 0; i < 3; i++) bit_clk(1'b0, s);
        mem_read(1'b0, 0, 1, "R12");

        check(r11_viol == 0, "R11", r11_viol, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule